// File: doc/BRIEF.md
# Ready Wait-State Timeout Monitor

This block sits beside the bus sequencer of an external memory-style port and decides, for every transaction the sequencer starts, whether that transaction may go ahead or must wait for a slow peripheral. The peripheral signals readiness on an asynchronous pin. The block samples that pin on the falling edge of the bus clock and stalls the transaction while the sampled level is low. When the wait lasts longer than a programmable limit, the block drops the transaction with a one-clock abort strobe and raises a sticky error-interrupt flag.

Ready gating is honoured only when it is enabled, the bus clock is driven out to the pin, and clock gating is off. In any other setup the peripheral is treated as always ready, and every transaction is granted on the clock after it starts. The wait limit is eight bits wide. It is held in a limit register that loads from the `maxWait` input on a load strobe and comes out of reset at its all-ones value. A limit of zero disables the timeout, so the transaction waits for ready indefinitely.

Top module: `ready_wait_monitor`

## Requirements
- R1: After reset, `proceed`, `hold`, `abortStrobe` and `errIrq` are all 0.
- R2: Ready gating is active only when `readyEnable`=1, `clkOutEnable`=1 and `clkGateEnable`=0. Otherwise a `txnStart` pulse gives a one-cycle `proceed` on the next clock and never raises `hold`. A transaction already waiting is granted on the clock after gating stops being active.
- R3: `readyPin` is sampled on the falling clock edge. A level change that occurs after a falling edge is not acted on until the rising edge that follows the next falling edge.
- R4: With a nonzero limit L and ready held low, `hold` is high for exactly L clocks, then `abortStrobe` pulses for exactly one clock, and no `proceed` is given.
- R5: With a limit of 0, a transaction waits with `hold` high for as long as ready stays low, with no abort, and is granted once ready rises.
- R6: `errIrq` is set by every abort and stays set until an `errClear` pulse. When an abort and a clear fall on the same clock, the flag stays set.
- R7: The wait count restarts at zero at the start of every transaction and on every clock in which sampled ready is high. A transaction that follows an aborted one therefore again holds for the full L clocks.
- R8: The limit register resets to 255 and loads `maxWait` on the clock in which `maxWaitLoad` is 1.
- R9: When sampled ready is high at a rising edge during a wait, `hold` falls and `proceed` pulses for one clock on that edge. `proceed` and `abortStrobe` are never high together.
- R10: A `txnStart` pulse while a transaction is waiting has no effect: it does not restart the wait count and does not change when the abort occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txnStart | input | 1 | One-cycle request from the sequencer to begin a transaction |
| readyPin | input | 1 | Asynchronous ready level from the peripheral, high = ready |
| readyEnable | input | 1 | Enables stalling on the ready pin |
| clkOutEnable | input | 1 | 1 when the bus clock is driven out to the peripheral |
| clkGateEnable | input | 1 | 1 when the bus clock is gated between transactions |
| maxWait | input | 8 | New wait limit in bus clocks; 0 means no timeout |
| maxWaitLoad | input | 1 | Loads `maxWait` into the limit register |
| errClear | input | 1 | One-cycle pulse that clears the error flag |
| proceed | output | 1 | One-cycle grant: the transaction may complete |
| hold | output | 1 | High while a transaction is stalled on ready |
| abortStrobe | output | 1 | One-cycle pulse when a stalled transaction is dropped |
| errIrq | output | 1 | Sticky timeout error flag |

## Verification
The bench aims at the exact length of the stall. An off-by-one in the limit compare shows up as L-1 or L+1 hold clocks, or as an abort one clock early or late. It raises ready just after a falling edge to expose a design that samples on the rising edge, because such a design would grant one clock early. It lines up an abort with a clear to catch a flag that lets the clear win. It runs back-to-back stalls and repeats a start request in mid-wait to expose a counter that carries over from the previous transaction or restarts on the extra request. It waits 300 clocks with a zero limit, where a counter that wraps around or treats zero as 256 would abort. It also covers each bypass condition on its own, where a design with a wrong gating term would stall.

// File: rtl/rwm_pkg.sv
package rwm_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } rwm_state_e;

  // Strobes issued by the control FSM to the wait-count datapath.
  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } rwm_strobe_t;

endpackage

// File: rtl/rwm_datapath.sv
module rwm_datapath
  import rwm_pkg::*;
#(
  parameter int WAIT_W      = 8,
  parameter int LIMIT_RESET = 255
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readyPin,
  input  logic [WAIT_W-1:0] maxWait,
  input  logic              maxWaitLoad,
  input  rwm_strobe_t       strobe,
  output logic              readySampled,
  output logic              limitHit,
  output logic              limitZero
);

  localparam logic [WAIT_W-1:0] LIMIT_INIT = WAIT_W'(LIMIT_RESET);
  localparam logic [WAIT_W-1:0] ONE        = WAIT_W'(1);
  localparam logic [WAIT_W-1:0] CNT_MAX    = '1;

  logic              readyFall;
  logic [WAIT_W-1:0] limitReg;
  logic [WAIT_W-1:0] waitCnt;

  // Ready pin captured on the falling edge; read by the FSM half a clock later.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) readyFall <= 1'b0;
    else       readyFall <= readyPin;
  end

  assign readySampled = readyFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            limitReg <= LIMIT_INIT;
    else if (maxWaitLoad) limitReg <= maxWait;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   waitCnt <= '0;
    else if (strobe.cntClear)                    waitCnt <= '0;
    else if (strobe.cntInc && waitCnt != CNT_MAX) waitCnt <= waitCnt + ONE;
  end

  assign limitZero = (limitReg == '0);
  assign limitHit  = !limitZero && (waitCnt == limitReg - ONE);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntInc && !strobe.cntClear && waitCnt != CNT_MAX) |=> waitCnt == $past(waitCnt) + ONE);

  assert_count_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClear |=> waitCnt == '0);

  assert_limit_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    maxWaitLoad |=> limitReg == $past(maxWait));

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.cntInc && strobe.cntClear));

endmodule

// File: rtl/rwm_control.sv
module rwm_control
  import rwm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txnStart,
  input  logic        readyEnable,
  input  logic        clkOutEnable,
  input  logic        clkGateEnable,
  input  logic        errClear,
  input  logic        readySampled,
  input  logic        limitHit,
  input  logic        limitZero,
  output rwm_strobe_t strobe,
  output logic        proceed,
  output logic        hold,
  output logic        abortStrobe,
  output logic        errIrq
);

  rwm_state_e state, stateNext;
  logic       proceedNext, abortNext, errNext;
  logic       gateOn, readyOk;

  assign gateOn  = readyEnable && clkOutEnable && !clkGateEnable;
  assign readyOk = !gateOn || readySampled;

  always_comb begin
    stateNext   = state;
    proceedNext = 1'b0;
    abortNext   = 1'b0;
    strobe      = '0;
    unique case (state)
      ST_IDLE: begin
        if (txnStart) begin
          strobe.cntClear = 1'b1;
          if (readyOk) proceedNext = 1'b1;
          else         stateNext   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (readyOk) begin
          stateNext       = ST_IDLE;
          proceedNext     = 1'b1;
          strobe.cntClear = 1'b1;
        end else if (limitHit) begin
          stateNext = ST_IDLE;
          abortNext = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign errNext = abortNext || (errIrq && !errClear);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      proceed     <= 1'b0;
      abortStrobe <= 1'b0;
      errIrq      <= 1'b0;
    end else begin
      state       <= stateNext;
      proceed     <= proceedNext;
      abortStrobe <= abortNext;
      errIrq      <= errNext;
    end
  end

  assign hold = (state == ST_WAIT);

  assert_bypass_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!hold && txnStart && !gateOn) |=> (proceed && !hold));

  assert_bypass_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hold && !gateOn) |=> (!hold && proceed));

  assert_abort_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    abortStrobe |=> !abortStrobe);

  assert_no_timeout_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hold && limitZero) |=> !abortStrobe);

  assert_err_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    abortStrobe |-> errIrq);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (errIrq && !errClear) |=> errIrq);

  assert_grant_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(proceed && abortStrobe));

  assert_ready_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hold && readySampled) |=> (proceed && !hold));

  assert_restart_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (hold && txnStart && !readyOk && !limitHit) |=> hold);

endmodule

// File: rtl/ready_wait_monitor.sv
module ready_wait_monitor
  import rwm_pkg::*;
#(
  parameter int WAIT_W      = 8,
  parameter int LIMIT_RESET = 255
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnStart,
  input  logic              readyPin,
  input  logic              readyEnable,
  input  logic              clkOutEnable,
  input  logic              clkGateEnable,
  input  logic [WAIT_W-1:0] maxWait,
  input  logic              maxWaitLoad,
  input  logic              errClear,
  output logic              proceed,
  output logic              hold,
  output logic              abortStrobe,
  output logic              errIrq
);

  rwm_strobe_t strobe;
  logic        readySampled, limitHit, limitZero;

  rwm_datapath #(
    .WAIT_W      (WAIT_W),
    .LIMIT_RESET (LIMIT_RESET)
  ) uDatapath (
    .clk          (clk),
    .rstN         (rstN),
    .readyPin     (readyPin),
    .maxWait      (maxWait),
    .maxWaitLoad  (maxWaitLoad),
    .strobe       (strobe),
    .readySampled (readySampled),
    .limitHit     (limitHit),
    .limitZero    (limitZero)
  );

  rwm_control uControl (
    .clk           (clk),
    .rstN          (rstN),
    .txnStart      (txnStart),
    .readyEnable   (readyEnable),
    .clkOutEnable  (clkOutEnable),
    .clkGateEnable (clkGateEnable),
    .errClear      (errClear),
    .readySampled  (readySampled),
    .limitHit      (limitHit),
    .limitZero     (limitZero),
    .strobe        (strobe),
    .proceed       (proceed),
    .hold          (hold),
    .abortStrobe   (abortStrobe),
    .errIrq        (errIrq)
  );

endmodule

// File: tb/ready_wait_monitor_test.sv
`timescale 1ns/100ps
module ready_wait_monitor_test;

  localparam int KIND_PROCEED = 1;
  localparam int KIND_ABORT   = 2;

  typedef struct {
    int kind;
    int cyc;
    string req;
  } evt_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txnStart = 1'b0;
  logic       readyPin = 1'b0;
  logic       readyEnable = 1'b1;
  logic       clkOutEnable = 1'b1;
  logic       clkGateEnable = 1'b0;
  logic [7:0] maxWait = 8'd0;
  logic       maxWaitLoad = 1'b0;
  logic       errClear = 1'b0;
  logic       proceed, hold, abortStrobe, errIrq;

  int   cyc = 0;
  int   holdCnt = 0;
  int   checks = 0;
  int   fails = 0;
  evt_t expQ[$];

  ready_wait_monitor uut (
    .clk           (clk),
    .rstN          (rstN),
    .txnStart      (txnStart),
    .readyPin      (readyPin),
    .readyEnable   (readyEnable),
    .clkOutEnable  (clkOutEnable),
    .clkGateEnable (clkGateEnable),
    .maxWait       (maxWait),
    .maxWaitLoad   (maxWaitLoad),
    .errClear      (errClear),
    .proceed       (proceed),
    .hold          (hold),
    .abortStrobe   (abortStrobe),
    .errIrq        (errIrq)
  );

  always #2 clk = ~clk;                 // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_evt(input int kind, input int at, input string req);
    evt_t e;
    e.kind = kind;
    e.cyc  = at;
    e.req  = req;
    expQ.push_back(e);
  endtask

  task automatic txn();
    txnStart = 1'b1;
    step();
    txnStart = 1'b0;
  endtask

  task automatic clearErr();
    errClear = 1'b1;
    step();
    errClear = 1'b0;
  endtask

  task automatic loadLimit(input int v);
    maxWait = 8'(v);
    maxWaitLoad = 1'b1;
    step();
    maxWaitLoad = 1'b0;
  endtask

  // Monitor: samples away from both clock edges and scores grant/abort events.
  initial begin
    forever begin
      @(posedge clk);
      #1.5;
      if (hold) holdCnt++;
      if (proceed || abortStrobe) begin
        int kind;
        kind = abortStrobe ? KIND_ABORT : KIND_PROCEED;
        if (proceed && abortStrobe)
          check(1'b0, "R9 exclusive", 2, 1);
        else if (expQ.size() == 0)
          check(1'b0, "R4/R5 unexpected event", kind, 0);
        else begin
          evt_t e;
          e = expQ.pop_front();
          check(e.kind == kind && e.cyc == cyc, e.req, kind * 100000 + cyc, e.kind * 100000 + e.cyc);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int c;
    repeat (3) step();
    rstN = 1'b1;
    // R1: reset state
    check(!proceed && !hold && !abortStrobe && !errIrq, "R1",
          {proceed, hold, abortStrobe, errIrq}, 0);

    // R8: default limit 255 after reset
    c = cyc; holdCnt = 0;
    expect_evt(KIND_ABORT, c + 256, "R8 default limit abort");
    txn();
    repeat (258) step();
    check(holdCnt == 255, "R8 hold length", holdCnt, 255);
    check(errIrq == 1'b1, "R6 set", errIrq, 1);

    clearErr();
    check(errIrq == 1'b0, "R6 clear", errIrq, 0);

    loadLimit(3);

    // R4: limit 3
    c = cyc; holdCnt = 0;
    expect_evt(KIND_ABORT, c + 4, "R4 abort time");
    txn();
    repeat (5) step();
    check(holdCnt == 3, "R4 hold length", holdCnt, 3);
    check(errIrq == 1'b1, "R6 set after abort", errIrq, 1);
    clearErr();

    // R6 set wins over clear; R7 full hold after prior abort
    c = cyc; holdCnt = 0;
    expect_evt(KIND_ABORT, c + 4, "R6 abort with clear");
    txn();
    step();
    step();
    errClear = 1'b1;
    step();
    errClear = 1'b0;
    check(errIrq == 1'b1, "R6 set wins", errIrq, 1);
    repeat (2) step();
    check(holdCnt == 3, "R7 restart count", holdCnt, 3);
    clearErr();

    // R9: ready before falling edge -> grant on next rising edge
    c = cyc; holdCnt = 0;
    expect_evt(KIND_PROCEED, c + 2, "R9 grant time");
    txn();
    readyPin = 1'b1;
    step();
    readyPin = 1'b0;
    check(hold == 1'b0, "R9 hold released", hold, 0);
    repeat (2) step();
    check(holdCnt == 1, "R9 hold length", holdCnt, 1);

    // R3: ready raised after the falling edge is seen one clock later
    c = cyc; holdCnt = 0;
    expect_evt(KIND_PROCEED, c + 3, "R3 grant time");
    txn();
    #1.5;
    readyPin = 1'b1;
    step();
    check(hold == 1'b1, "R3 not yet sampled", hold, 1);
    step();
    readyPin = 1'b0;
    check(hold == 1'b0, "R3 sampled", hold, 0);
    repeat (2) step();
    check(holdCnt == 2, "R3 hold length", holdCnt, 2);

    // R10: extra start during a wait is ignored
    c = cyc; holdCnt = 0;
    expect_evt(KIND_ABORT, c + 4, "R10 abort time");
    txn();
    step();
    txnStart = 1'b1;
    step();
    txnStart = 1'b0;
    repeat (3) step();
    check(holdCnt == 3, "R10 hold length", holdCnt, 3);
    clearErr();

    // R2: each bypass condition grants at once
    for (int k = 0; k < 3; k++) begin
      readyEnable   = (k != 0);
      clkOutEnable  = (k != 1);
      clkGateEnable = (k == 2);
      c = cyc; holdCnt = 0;
      expect_evt(KIND_PROCEED, c + 1, "R2 bypass grant");
      txn();
      check(hold == 1'b0, "R2 no hold", hold, 0);
      step();
      check(holdCnt == 0, "R2 no hold count", holdCnt, 0);
    end
    readyEnable = 1'b1; clkOutEnable = 1'b1; clkGateEnable = 1'b0;

    // R2: gating switched off in mid-wait
    c = cyc; holdCnt = 0;
    expect_evt(KIND_PROCEED, c + 3, "R2 mid-wait release");
    txn();
    step();
    clkGateEnable = 1'b1;
    step();
    clkGateEnable = 1'b0;
    repeat (2) step();
    check(holdCnt == 2, "R2 mid-wait hold length", holdCnt, 2);

    // R5: limit 0 waits forever
    loadLimit(0);
    c = cyc; holdCnt = 0;
    expect_evt(KIND_PROCEED, c + 301, "R5 late grant");
    txn();
    repeat (299) step();
    readyPin = 1'b1;
    step();
    readyPin = 1'b0;
    repeat (2) step();
    check(holdCnt == 300, "R5 hold length", holdCnt, 300);
    check(errIrq == 1'b0, "R5 no error", errIrq, 0);

    check(expQ.size() == 0, "R4/R9 missing events", expQ.size(), 0);
    finishRun();
  end

endmodule